// File: doc/BRIEF.md
# Prioritized UART Interrupt Status Encoder

This block gathers the pending interrupt sources of a serial port and reduces them to one status byte that software reads to find the most urgent cause. The lower six bits carry a code for the winning source. Bit 0 is an active-low "pending" flag. The two upper bits show whether the FIFOs are in use. A request line, active high, goes to the interrupt controller.

Once a pending code is shown, it is frozen until software reads the status byte. That read is signalled by a one-cycle strobe. A source of higher priority that arrives in the meantime does not replace the shown code. The register picks the current winner again at the read, so lower sources appear only after the higher one has been cleared and the register has been read again.

The flow-control indications are reported only while the enhanced-feature enable is set. The Xoff indication is sticky and is cleared only when an Xon is received. Clearing each source belongs to the surrounding register logic.

Top module: `irq_status_top`

## Requirements
- R1: After reset, the status byte reads 0x01 and the request line is low.
- R2: When the shown code is idle (bit 0 = 1) or the read strobe is high at a clock edge, the low six bits load the code of the highest pending source at that edge. The sources, from highest to lowest priority, and their codes are: line status error 0x06, receive data 0x04 or 0x0C, transmit holding empty 0x02, modem status change 0x00, Xoff/special character 0x10, flow-control line change 0x20. With no source pending the code is 0x01.
- R3: When the receive-timeout and receive-ready flags are both pending, the timeout code 0x0C is shown rather than 0x04.
- R4: Bit 0 is 0 exactly when a source is shown, and the request line is its inverse.
- R5: Bits 7:6 read 11 one cycle after the FIFO-enable flag is 1, and 00 one cycle after it is 0.
- R6: While the enhanced-feature enable is 0, the Xoff and flow-control sources are masked from the code and from the request line.
- R7: An Xoff detection sets a held indication on the next edge, which is reported as code 0x10 on the edge after that. The indication stays set until an Xon is received. If Xoff and Xon arrive in the same cycle, the Xon wins and the indication is left clear.
- R8: While a pending code is shown and the read strobe is low, the low six bits stay unchanged, whatever the sources do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lineErr | input | 1 | Receive line status error pending |
| rxReady | input | 1 | Received data reached trigger level |
| rxTimeout | input | 1 | Receive data timeout |
| txEmpty | input | 1 | Transmit holding register empty |
| modemChg | input | 1 | Modem status change |
| xoffDet | input | 1 | Xoff or special character detected (pulse) |
| xonRcvd | input | 1 | Xon received (pulse) |
| flowChg | input | 1 | Flow-control line change of state |
| fifoEn | input | 1 | FIFOs enabled |
| enhEn | input | 1 | Enhanced-feature enable |
| statusRd | input | 1 | Status register read strobe |
| statusByte | output | FIFO_FLAG_W+6 | Status register value |
| irqReq | output | 1 | Interrupt request, active high |

## Verification
Every result except the Xoff path is due on the first clock edge after its stimulus. An Xoff detection goes through the held indication and shows in the code on the second edge. The driver stores one expected byte for each edge it wants checked. The monitor compares that byte one time step after the edge, while inputs change only three steps after the edge. The hold-until-read behaviour is checked by raising a higher source while the read strobe is low, and then raising the strobe.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int CODE_W = 6;

  localparam logic [CODE_W-1:0] CODE_IDLE    = 6'b000001;
  localparam logic [CODE_W-1:0] CODE_LINE    = 6'b000110;
  localparam logic [CODE_W-1:0] CODE_RXDATA  = 6'b000100;
  localparam logic [CODE_W-1:0] CODE_RXTOUT  = 6'b001100;
  localparam logic [CODE_W-1:0] CODE_TXEMPTY = 6'b000010;
  localparam logic [CODE_W-1:0] CODE_MODEM   = 6'b000000;
  localparam logic [CODE_W-1:0] CODE_XOFF    = 6'b010000;
  localparam logic [CODE_W-1:0] CODE_FLOW    = 6'b100000;

  typedef struct packed {
    logic lineErr;
    logic rxTimeout;
    logic rxReady;
    logic txEmpty;
    logic modemChg;
    logic flowChg;
  } srcFlags_t;

  typedef struct packed {
    logic loadCode;
    logic xoffHeld;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xoffDet,
  input  logic        xonRcvd,
  input  logic        statusRd,
  input  logic        shownIdle,
  output ctrlStrobe_t strb
);
  logic xoffHeldQ;

  // Held Xoff indication; a received Xon clears it and wins over a same-cycle set.
  always_ff @(posedge clk) begin
    if (!rst_n)       xoffHeldQ <= 1'b0;
    else if (xonRcvd) xoffHeldQ <= 1'b0;
    else if (xoffDet) xoffHeldQ <= 1'b1;
  end

  always_comb begin
    strb.loadCode = statusRd | shownIdle;
    strb.xoffHeld = xoffHeldQ;
  end
endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
#(
  parameter int FIFO_FLAG_W = 2,
  localparam int ST_W = FIFO_FLAG_W + CODE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  srcFlags_t       src,
  input  logic            fifoEn,
  input  logic            enhEn,
  input  ctrlStrobe_t     strb,
  output logic [ST_W-1:0] statusByte,
  output logic            shownIdle
);
  logic [CODE_W-1:0]      nextCode;
  logic [CODE_W-1:0]      codeQ;
  logic [FIFO_FLAG_W-1:0] fifoFlagQ;

  // Fixed-priority selection, highest first.
  always_comb begin
    if (src.lineErr)                  nextCode = CODE_LINE;
    else if (src.rxTimeout)           nextCode = CODE_RXTOUT;
    else if (src.rxReady)             nextCode = CODE_RXDATA;
    else if (src.txEmpty)             nextCode = CODE_TXEMPTY;
    else if (src.modemChg)            nextCode = CODE_MODEM;
    else if (enhEn && strb.xoffHeld)  nextCode = CODE_XOFF;
    else if (enhEn && src.flowChg)    nextCode = CODE_FLOW;
    else                              nextCode = CODE_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codeQ     <= CODE_IDLE;
      fifoFlagQ <= '0;
    end else begin
      if (strb.loadCode) codeQ <= nextCode;
      fifoFlagQ <= {FIFO_FLAG_W{fifoEn}};
    end
  end

  assign statusByte = {fifoFlagQ, codeQ};
  assign shownIdle  = codeQ[0];
endmodule

// File: rtl/irq_status_top.sv
module irq_status_top
  import irq_status_pkg::*;
#(
  parameter int FIFO_FLAG_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lineErr,
  input  logic                          rxReady,
  input  logic                          rxTimeout,
  input  logic                          txEmpty,
  input  logic                          modemChg,
  input  logic                          xoffDet,
  input  logic                          xonRcvd,
  input  logic                          flowChg,
  input  logic                          fifoEn,
  input  logic                          enhEn,
  input  logic                          statusRd,
  output logic [FIFO_FLAG_W+CODE_W-1:0] statusByte,
  output logic                          irqReq
);
  srcFlags_t   src;
  ctrlStrobe_t strb;
  logic        shownIdle;

  always_comb begin
    src.lineErr   = lineErr;
    src.rxTimeout = rxTimeout;
    src.rxReady   = rxReady;
    src.txEmpty   = txEmpty;
    src.modemChg  = modemChg;
    src.flowChg   = flowChg;
  end

  irq_status_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .xoffDet  (xoffDet),
    .xonRcvd  (xonRcvd),
    .statusRd (statusRd),
    .shownIdle(shownIdle),
    .strb     (strb)
  );

  irq_status_dp #(.FIFO_FLAG_W(FIFO_FLAG_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src),
    .fifoEn    (fifoEn),
    .enhEn     (enhEn),
    .strb      (strb),
    .statusByte(statusByte),
    .shownIdle (shownIdle)
  );

  assign irqReq = ~shownIdle;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int FIFO_FLAG_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lineErr,
  input logic                   rxReady,
  input logic                   rxTimeout,
  input logic                   txEmpty,
  input logic                   modemChg,
  input logic                   flowChg,
  input logic                   fifoEn,
  input logic                   enhEn,
  input logic                   statusRd,
  input logic [FIFO_FLAG_W+5:0] statusByte
);
  logic canLoad;
  assign canLoad = statusByte[0] | statusRd;

  // R5
  a_r5_fifo_flags: assert property (@(posedge clk) disable iff (!rst_n)
    fifoEn |=> statusByte[FIFO_FLAG_W+5:6] == {FIFO_FLAG_W{1'b1}});

  // R8
  a_r8_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!statusByte[0] && !statusRd) |=> $stable(statusByte[5:0]));

  // R2
  a_r2_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (canLoad && lineErr) |=> statusByte[5:0] == 6'b000110);

  // R3
  a_r3_timeout_first: assert property (@(posedge clk) disable iff (!rst_n)
    (canLoad && !lineErr && rxTimeout && rxReady) |=> statusByte[5:0] == 6'b001100);

  // R6
  a_r6_enh_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (canLoad && !enhEn) |=> statusByte[5:4] == 2'b00);

  // R6
  a_r6_idle_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (canLoad && !enhEn && !lineErr && !rxReady && !rxTimeout && !txEmpty && !modemChg)
      |=> statusByte[0]);
endmodule

bind irq_status_top irq_status_chk #(.FIFO_FLAG_W(FIFO_FLAG_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .lineErr   (lineErr),
  .rxReady   (rxReady),
  .rxTimeout (rxTimeout),
  .txEmpty   (txEmpty),
  .modemChg  (modemChg),
  .flowChg   (flowChg),
  .fifoEn    (fifoEn),
  .enhEn     (enhEn),
  .statusRd  (statusRd),
  .statusByte(statusByte)
);

// File: tb/irq_status_top_tb_top.sv
module irq_status_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lineErr = 0, rxReady = 0, rxTimeout = 0, txEmpty = 0, modemChg = 0;
  logic xoffDet = 0, xonRcvd = 0, flowChg = 0, fifoEn = 0, enhEn = 0, statusRd = 0;
  logic [7:0] statusByte;
  logic irqReq;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_status_top dut_i (
    .clk(clk), .rst_n(rst_n), .lineErr(lineErr), .rxReady(rxReady),
    .rxTimeout(rxTimeout), .txEmpty(txEmpty), .modemChg(modemChg),
    .xoffDet(xoffDet), .xonRcvd(xonRcvd), .flowChg(flowChg), .fifoEn(fifoEn),
    .enhEn(enhEn), .statusRd(statusRd), .statusByte(statusByte), .irqReq(irqReq)
  );

  // Monitor: compares one step after each edge for which an expectation was queued.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (statusByte !== it.exp) begin
        errors++;
        $display("FAIL %s status actual=%02h expected=%02h", it.req, statusByte, it.exp);
      end
      checks++;
      if (irqReq !== ~it.exp[0]) begin
        errors++;
        $display("FAIL R4 irqReq actual=%b expected=%b (%s)", irqReq, ~it.exp[0], it.req);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic chk(input logic [7:0] exp, input string req);
    expItem_t it;
    it.exp = exp;
    it.req = req;
    expQ.push_back(it);
    @(posedge clk); #3;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    chk(8'h01, "R1");                                  // reset value
    fifoEn = 1; chk(8'hC1, "R5");
    fifoEn = 0; chk(8'h01, "R5");

    // R8: hold until read
    txEmpty = 1; chk(8'h02, "R2");
    lineErr = 1; chk(8'h02, "R8");
    statusRd = 1; chk(8'h06, "R2");
    statusRd = 0; lineErr = 0; chk(8'h06, "R8");
    statusRd = 1; chk(8'h02, "R2");
    txEmpty = 0; chk(8'h01, "R4");

    // priorities with read strobe high
    rxReady = 1; rxTimeout = 1; txEmpty = 1; chk(8'h0C, "R3");
    rxTimeout = 0; chk(8'h04, "R2");
    rxReady = 0; chk(8'h02, "R2");
    txEmpty = 0; modemChg = 1; chk(8'h00, "R2");
    modemChg = 0; chk(8'h01, "R2");

    // enhanced-feature sources
    enhEn = 0; flowChg = 1; chk(8'h01, "R6");
    enhEn = 1; chk(8'h20, "R2");
    xoffDet = 1; chk(8'h20, "R7");
    xoffDet = 0; flowChg = 0; chk(8'h10, "R7");
    chk(8'h10, "R7");
    enhEn = 0; chk(8'h01, "R6");
    enhEn = 1; chk(8'h10, "R7");
    xonRcvd = 1; chk(8'h10, "R7");
    xonRcvd = 0; chk(8'h01, "R7");
    xoffDet = 1; xonRcvd = 1; chk(8'h01, "R7");
    xoffDet = 0; xonRcvd = 0; chk(8'h01, "R7");

    fifoEn = 1; lineErr = 1; chk(8'hC6, "R5");
    lineErr = 0; fifoEn = 0; tick(); tick();

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule